// File: doc/BRIEF.md
# Cascadable Global Timer Group

This block holds four down-counting timers that live inside an interrupt controller. Each timer has a base count and a current count. When a running timer is at zero and receives a count tick, it reloads its base count and signals an expiry. The registered expiry becomes a one-cycle interrupt request. A destination mask on each timer sends that request to processor core 0, to core 1, to both cores or to neither. Timer requests only drive these normal per-core request outputs. No critical-level output exists.

One group-wide setting picks the count tick. The tick is either every cycle of the bus clock, or each rising edge of a slow real-time clock input. That input first passes through a two-flop synchronizer and then an edge detector. A timer can be chained to the timer below it. A chained timer then counts only when its lower neighbour rolls over from zero, so the pair behaves as one longer counter. Only the upper timer of a chain raises an interrupt.

Software drives a simple write port and a combinational read port. Timer `i` has its base count at address `4*i`, its control at `4*i+1` and its read-only current count at `4*i+2`. The group setting is at address 16.

Top module: `gtmr_group`

## Requirements
- R1: After reset every base and current count reads 0, every control word reads 1 (inhibited, mask 0), the group setting reads 0 and both request outputs are low.
- R2: A base-count write to an inhibited timer sets its current count to the written value from the next cycle on. A base-count write to a running timer leaves the current count untouched, and the new base count is used from the next reload on.
- R3: In bus-clock mode (group setting bit 0 = 0) a running timer decrements once per clock. At count 0 the next tick reloads the base count, so expiries repeat every base+1 ticks.
- R4: Each expiry gives a request pulse exactly one cycle wide. The pulse is visible in the cycle that follows the clock edge that reloaded the count, so with base count B the first pulse comes B+1 edges after the edge that clears the inhibit.
- R5: While control bit 0 (inhibit) is 1, the current count does not change.
- R6: Control bits [2:1] form the destination mask. Bit 1 sends the timer's request to `irq_core0[i]` and bit 2 sends it to `irq_core1[i]`. Both bits set deliver to both cores, and a zero mask delivers to neither.
- R7: Group setting bit i+1 (i = 1..3) chains timer i to timer i-1. Timer i then decrements only on a rollover of timer i-1 and holds its count while timer i-1 is inhibited. Timer i-1 raises no request while the chain is on.
- R8: With group setting bit 0 = 1, each running timer decrements once per rising edge of `rtc_in`, however long the input stays high, and holds its count while `rtc_in` is static.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| rtc_in | input | 1 | Slow real-time clock input, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| irq_core0 | output | 4 | Per-timer request pulses to core 0 |
| irq_core1 | output | 4 | Per-timer request pulses to core 1 |

## Verification
A register write takes effect at the edge that samples the strobe. The bench therefore reads back only at the falling edge after that edge. In bus-clock mode the count moves one step per edge. A timer loaded with B and released at edge P shows B-k at the falling edge after P+k, and its first request pulse appears at the falling edge after P+B+1. On the real-time input, a rising edge reaches the counter two edges after it is first sampled, so the bench leaves several bus cycles after each edge before reading. Request pulses are counted at every falling edge. Periods are checked over windows that are whole multiples of the expected period and start after the first reload, so the counts are exact whatever the phase.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
  localparam int NCORE = 2;

  localparam logic [1:0] FLD_BASE = 2'd0;
  localparam logic [1:0] FLD_CTRL = 2'd1;
  localparam logic [1:0] FLD_CUR  = 2'd2;
endpackage

// File: rtl/gtmr_tick_src.sv
module gtmr_tick_src (
  input  logic clk,
  input  logic rst_n,
  input  logic rtc_in,
  input  logic sel_rtc,
  output logic tick_o
);
  logic sync1, sync2, sync3;
  logic rtc_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      sync3 <= 1'b0;
    end else begin
      sync1 <= rtc_in;
      sync2 <= sync1;
      sync3 <= sync2;
    end
  end

  assign rtc_rise = sync2 & ~sync3;
  assign tick_o   = sel_rtc ? rtc_rise : 1'b1;

  AST_RTC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rtc && tick_o) |=> !(sel_rtc && tick_o)); // R8
endmodule

// File: rtl/gtmr_cell.sv
module gtmr_cell #(
  parameter int CW    = 32,
  parameter int NCORE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_base,
  input  logic             wr_ctrl,
  input  logic [CW-1:0]    wr_data,
  output logic [CW-1:0]    cur_o,
  output logic [CW-1:0]    base_o,
  output logic             inh_o,
  output logic [NCORE-1:0] dest_o,
  output logic             expire_o
);
  function automatic logic f_expire(logic t, logic inh, logic [CW-1:0] c);
    return t & ~inh & (c == '0);
  endfunction

  function automatic logic [CW-1:0] f_next(logic t, logic inh,
                                           logic [CW-1:0] c, logic [CW-1:0] b);
    if (!t || inh)    return c;
    else if (c == '0) return b;
    else              return c - 1'b1;
  endfunction

  logic [CW-1:0]    cur_q, base_q;
  logic             inh_q;
  logic [NCORE-1:0] dest_q;
  logic             load_now;

  assign load_now = wr_base & inh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= '0;
      base_q <= '0;
      inh_q  <= 1'b1;
      dest_q <= '0;
    end else begin
      if (load_now) cur_q <= wr_data;
      else          cur_q <= f_next(tick, inh_q, cur_q, base_q);
      if (wr_base) base_q <= wr_data;
      if (wr_ctrl) begin
        inh_q  <= wr_data[0];
        dest_q <= wr_data[NCORE:1];
      end
    end
  end

  assign expire_o = f_expire(tick, inh_q, cur_q);
  assign cur_o    = cur_q;
  assign base_o   = base_q;
  assign inh_o    = inh_q;
  assign dest_o   = dest_q;

  AST_LOAD_INHIBITED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_base && inh_q) |=> (cur_q == $past(wr_data))); // R2
  AST_HOLD_INHIBITED: assert property (@(posedge clk) disable iff (!rst_n)
    (inh_q && !wr_base) |=> $stable(cur_q)); // R5
  AST_RELOAD_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> (cur_q == $past(base_q))); // R3
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !inh_q && cur_q != '0) |=> (cur_q == $past(cur_q) - 1'b1)); // R3
endmodule

// File: rtl/gtmr_route.sv
module gtmr_route #(
  parameter int NTMR  = 4,
  parameter int NCORE = 2
) (
  input  logic [NTMR-1:0]             irq_i,
  input  logic [NTMR-1:0][NCORE-1:0]  dest_i,
  output logic [NCORE-1:0][NTMR-1:0]  core_irq_o
);
  for (genvar c = 0; c < NCORE; c++) begin : g_core
    for (genvar t = 0; t < NTMR; t++) begin : g_tmr
      assign core_irq_o[c][t] = irq_i[t] & dest_i[t][c];
    end
  end
endmodule

// File: rtl/gtmr_group.sv
module gtmr_group #(
  parameter  int NTMR = 4,
  parameter  int CW   = 32,
  localparam int TIW  = (NTMR > 1) ? $clog2(NTMR) : 1,
  localparam int AW   = TIW + 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rtc_in,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [CW-1:0]   wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [CW-1:0]   rd_data,
  output logic [NTMR-1:0] irq_core0,
  output logic [NTMR-1:0] irq_core1
);
  import gtmr_pkg::*;

  logic                            cfg_rtc;
  logic [NTMR-1:0]                 cfg_chain;
  logic                            base_tick;
  logic [NTMR-1:0]                 tick_v, exp_v, inh_v, irq_q, chain_up;
  logic [NTMR-1:0][CW-1:0]         cur_v, base_v;
  logic [NTMR-1:0][NCORE-1:0]      dest_v;
  logic [NCORE-1:0][NTMR-1:0]      core_irq;
  logic                            wr_grp;

  assign wr_grp = wr_en & wr_addr[AW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_rtc   <= 1'b0;
      cfg_chain <= '0;
    end else if (wr_grp) begin
      cfg_rtc   <= wr_data[0];
      cfg_chain <= {wr_data[NTMR:2], 1'b0};
    end
  end

  gtmr_tick_src u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .rtc_in  (rtc_in),
    .sel_rtc (cfg_rtc),
    .tick_o  (base_tick)
  );

  always_comb begin
    logic carry;
    carry = base_tick;
    for (int i = 0; i < NTMR; i++) begin
      tick_v[i] = cfg_chain[i] ? carry : base_tick;
      carry     = tick_v[i] & ~inh_v[i] & (cur_v[i] == '0);
    end
  end

  for (genvar i = 0; i < NTMR; i++) begin : g_cell
    logic sel_me;
    assign sel_me = wr_en & ~wr_addr[AW-1] & (wr_addr[AW-2:2] == TIW'(i));

    gtmr_cell #(.CW(CW), .NCORE(NCORE)) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick_v[i]),
      .wr_base  (sel_me && wr_addr[1:0] == FLD_BASE),
      .wr_ctrl  (sel_me && wr_addr[1:0] == FLD_CTRL),
      .wr_data  (wr_data),
      .cur_o    (cur_v[i]),
      .base_o   (base_v[i]),
      .inh_o    (inh_v[i]),
      .dest_o   (dest_v[i]),
      .expire_o (exp_v[i])
    );
  end

  assign chain_up = {1'b0, cfg_chain[NTMR-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= exp_v & ~chain_up;
  end

  gtmr_route #(.NTMR(NTMR), .NCORE(NCORE)) u_route (
    .irq_i      (irq_q),
    .dest_i     (dest_v),
    .core_irq_o (core_irq)
  );

  assign irq_core0 = core_irq[0];
  assign irq_core1 = core_irq[1];

  always_comb begin
    rd_data = '0;
    if (rd_addr[AW-1]) begin
      rd_data = CW'({cfg_chain, cfg_rtc});
    end else begin
      for (int i = 0; i < NTMR; i++) begin
        if (rd_addr[AW-2:2] == TIW'(i)) begin
          case (rd_addr[1:0])
            FLD_BASE: rd_data = base_v[i];
            FLD_CTRL: rd_data = CW'({dest_v[i], inh_v[i]});
            FLD_CUR:  rd_data = cur_v[i];
            default:  rd_data = '0;
          endcase
        end
      end
    end
  end

  for (genvar i = 0; i < NTMR; i++) begin : g_chk
    AST_IRQ_FROM_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_core0[i] || irq_core1[i]) |-> $past(exp_v[i])); // R4
  end

  for (genvar i = 0; i < NTMR - 1; i++) begin : g_chain_chk
    AST_CHAIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_chain[i+1] && $past(cfg_chain[i+1])) |-> !(irq_core0[i] || irq_core1[i])); // R7
  end
endmodule

// File: tb/sim_gtmr_group.sv
`timescale 1ns/1ps
module sim_gtmr_group;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rtc_in = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [3:0]  irq_core0, irq_core1;

  int n_run = 0;
  int n_fail = 0;
  int pc0 [4];
  int pc1 [4];
  int s0 [4];
  int s1 [4];

  always #2 clk = ~clk;

  gtmr_group u0 (
    .clk(clk), .rst_n(rst_n), .rtc_in(rtc_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_core0(irq_core0), .irq_core1(irq_core1)
  );

  initial begin
    for (int i = 0; i < 4; i++) begin pc0[i] = 0; pc1[i] = 0; end
  end

  always @(negedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (irq_core0[i]) pc0[i] = pc0[i] + 1;
      if (irq_core1[i]) pc1[i] = pc1[i] + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    #0.5;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    rd_addr = a;
    #0.1;
    v = rd_data;
  endtask

  task automatic step(input int k);
    repeat (k) @(negedge clk);
    #0.5;
  endtask

  task automatic snap();
    for (int i = 0; i < 4; i++) begin s0[i] = pc0[i]; s1[i] = pc1[i]; end
  endtask

  task automatic rtc_pulse(input int hi);
    @(negedge clk); rtc_in = 1'b1;
    repeat (hi) @(negedge clk);
    rtc_in = 1'b0;
    repeat (5) @(negedge clk);
    #0.5;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    step(1);
    for (int i = 0; i < 4; i++) begin
      rd(5'(4*i + 2), v); chk("R1 cur", v, 0);
      rd(5'(4*i + 1), v); chk("R1 ctrl", v, 1);
    end
    step(1);
    for (int i = 0; i < 4; i++) begin
      rd(5'(4*i), v); chk("R1 base", v, 0);
    end
    rd(5'd16, v); chk("R1 cfg", v, 0);
    chk("R1 irq", {24'd0, irq_core1, irq_core0}, 0);
  endtask

  task automatic t_count();
    logic [31:0] v, w;
    reg_wr(5'd0, 32'd5);
    rd(5'd2, v); chk("R2 load inhibited", v, 5);
    step(5);
    rd(5'd2, v); chk("R5 hold inhibited", v, 5);
    reg_wr(5'd1, 32'h2);
    snap();
    step(3);
    rd(5'd2, v); chk("R3 decrement", v, 2);
    step(2);
    rd(5'd2, v); chk("R3 reach zero", v, 0);
    chk("R4 no early pulse", pc0[0] - s0[0], 0);
    step(1);
    chk("R4 first pulse", pc0[0] - s0[0], 1);
    chk("R6 core1 masked", pc1[0] - s1[0], 0);
    rd(5'd2, v); chk("R3 reload", v, 5);
    step(1);
    chk("R4 one cycle wide", pc0[0] - s0[0], 1);
    snap(); step(18);
    chk("R3 period base+1", pc0[0] - s0[0], 3);
    reg_wr(5'd0, 32'd9);
    rd(5'd2, v); chk("R2 running not loaded", {31'd0, v <= 32'd5}, 1);
    step(10); snap(); step(60);
    chk("R2 new base period", pc0[0] - s0[0], 6);
    reg_wr(5'd1, 32'h6);
    step(10); snap(); step(60);
    chk("R6 both core0", pc0[0] - s0[0], 6);
    chk("R6 both core1", pc1[0] - s1[0], 6);
    reg_wr(5'd1, 32'h0);
    snap(); step(60);
    chk("R6 none core0", pc0[0] - s0[0], 0);
    chk("R6 none core1", pc1[0] - s1[0], 0);
    reg_wr(5'd1, 32'h1);
    rd(5'd2, v); step(7); rd(5'd2, w);
    chk("R5 stopped", w, v);
  endtask

  task automatic t_chain();
    logic [31:0] v;
    reg_wr(5'd0, 32'd2);
    reg_wr(5'd4, 32'd1);
    reg_wr(5'd16, 32'h4);
    reg_wr(5'd5, 32'h2);
    step(10);
    rd(5'd6, v); chk("R7 upper waits", v, 1);
    reg_wr(5'd1, 32'h2);
    snap(); step(60);
    chk("R7 upper period", pc0[1] - s0[1], 10);
    chk("R7 lower quiet", pc0[0] - s0[0], 0);
    reg_wr(5'd1, 32'h1);
    reg_wr(5'd5, 32'h1);
    reg_wr(5'd16, 32'h0);
  endtask

  task automatic t_rtc();
    logic [31:0] v;
    reg_wr(5'd16, 32'h1);
    reg_wr(5'd8, 32'd3);
    reg_wr(5'd9, 32'h6);
    step(20);
    rd(5'd10, v); chk("R8 static rtc holds", v, 3);
    rtc_pulse(10);
    rd(5'd10, v); chk("R8 long high one step", v, 2);
    rtc_pulse(4);
    rd(5'd10, v); chk("R8 second edge", v, 1);
    snap();
    rtc_pulse(4);
    rtc_pulse(4);
    chk("R8 expiry core0", pc0[2] - s0[2], 1);
    chk("R8 expiry core1", pc1[2] - s1[2], 1);
    rd(5'd10, v); chk("R8 reload", v, 3);
    reg_wr(5'd9, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_count();
    t_chain();
    t_rtc();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule